// File: doc/BRIEF.md
# Delay-Locked-Loop Lock and Force Sequencer

This block brings up the delay-locked loop of a memory PHY after reset. A single `go` pulse starts a fixed sequence of register writes on a 32-bit control word with a one-cycle write strobe. The first write sets the start-point and increment fields with the loop off. The second turns the loop on. The third pulses the start bit.

The block then watches the PHY status word. It samples it once every `poll_gap + 1` cycles until the three low status bits all read one. At that point it captures the 8-bit measured delay from the status word and writes it back into the top byte of the control word as a forced delay. That forced value lets the delay stay fixed if the loop is later shut down for low-frequency operation. When `dll_off` was high at start, one more write clears the loop-enable bit, and it does so only after the force value is in place.

`locked` marks a finished sequence. `lock_fail` marks a lock that never arrived within `TMO_LIM` poll cycles. Both hold until reset.

Top module: `dll_lock_ctrl`

## Requirements
- R1: While reset is low and right after it, `ctl_we`, `locked` and `lock_fail` are 0.
- R2: A `go` seen at a clock edge in idle produces three writes on consecutive cycles, beginning the next cycle. The first write is `INIT_WORD` (default 0x00101000, bits 1 and 0 clear). The second is `INIT_WORD` with bit 1 (loop enable) set. The third also has bit 0 (start) set.
- R3: Lock is accepted only when `stat_word[2:0]` is 3'b111. Any other pattern keeps the block polling with no write.
- R4: The status word is sampled once every `poll_gap`+1 cycles. If lock is already reported, the force write comes exactly `poll_gap`+2 cycles after the start write.
- R5: The force write equals `INIT_WORD` with bits [31:24] replaced by `stat_word[13:6]` and bits 1 and 0 set. All other status bits have no effect on it.
- R6: `dll_off` is sampled together with `go`. When it is 1, the cycle after the force write carries one more write: the force word with bit 1 cleared. When it is 0, no write follows the force write.
- R7: `locked` rises the cycle after the last write of the sequence and stays high until reset.
- R8: Without lock, `lock_fail` rises exactly `TMO_LIM`+1 cycles after the start write. No further write is made, and `lock_fail` stays high until reset.
- R9: `go` has no effect while a sequence runs or after it has ended in `locked` or `lock_fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start request, sampled in idle |
| dll_off | input | 1 | Clear the loop-enable bit after forcing |
| poll_gap | input | GAP_W | Idle cycles between status samples |
| stat_word | input | 32 | PHY status word |
| ctl_word | output | 32 | PHY control word, valid with `ctl_we` |
| ctl_we | output | 1 | Control write strobe |
| locked | output | 1 | Sequence finished, delay forced |
| lock_fail | output | 1 | Lock not seen within the limit |

## Verification
Write timing is measured against the start write, which serves as the timing origin. The force write is due `poll_gap`+2 cycles after it, `locked` one cycle after the last write, and `lock_fail` `TMO_LIM`+1 cycles after it. A monitor samples the outputs at each falling edge and stamps every write and every rise of `locked` or `lock_fail` with a cycle number. All checks compare differences of these stamps, so they do not depend on when `go` was driven. Ignored stimuli (partial lock patterns, a late `go`) are checked by the write count and the stamps that follow.

// File: rtl/dll_lock_ctrl.sv
module dll_lock_ctrl #(
  parameter logic [31:0] INIT_WORD = 32'h0010_1000,
  parameter int GAP_W   = 8,
  parameter int TMO_LIM = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             dll_off,
  input  logic [GAP_W-1:0] poll_gap,
  input  logic [31:0]      stat_word,
  output logic [31:0]      ctl_word,
  output logic             ctl_we,
  output logic             locked,
  output logic             lock_fail
);
  localparam int TMO_W = $clog2(TMO_LIM + 1);
  localparam logic [31:0] BASE = INIT_WORD & 32'h00FF_FFFC;

  typedef enum logic [3:0] {
    S_IDLE, S_PRM, S_ON, S_STRT, S_POLL, S_FRC, S_OFF, S_DONE, S_FAIL
  } st_t;

  st_t              st;
  logic [GAP_W-1:0] gap_cnt;
  logic [TMO_W-1:0] tmo_cnt;
  logic [7:0]       lv;
  logic             off_q;

  wire smp = (gap_cnt == '0);
  wire hit = smp && (stat_word[2:0] == 3'b111);
  wire [31:0] frc_word = BASE | {lv, 24'h0} | 32'h3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      gap_cnt <= '0;
      tmo_cnt <= '0;
      lv      <= '0;
      off_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          off_q <= dll_off;
          st    <= S_PRM;
        end
        S_PRM:  st <= S_ON;
        S_ON:   st <= S_STRT;
        S_STRT: begin
          gap_cnt <= poll_gap;
          tmo_cnt <= '0;
          st      <= S_POLL;
        end
        S_POLL: begin
          if (hit) begin
            lv <= stat_word[13:6];
            st <= S_FRC;
          end else if (tmo_cnt == TMO_W'(TMO_LIM - 1)) begin
            st <= S_FAIL;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
            gap_cnt <= smp ? poll_gap : gap_cnt - 1'b1;
          end
        end
        S_FRC:  st <= off_q ? S_OFF : S_DONE;
        S_OFF:  st <= S_DONE;
        default: st <= st;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_PRM:   ctl_word = INIT_WORD & ~32'h3;
      S_ON:    ctl_word = (INIT_WORD & ~32'h3) | 32'h2;
      S_STRT:  ctl_word = INIT_WORD | 32'h3;
      S_FRC:   ctl_word = frc_word;
      S_OFF:   ctl_word = frc_word & ~32'h2;
      default: ctl_word = '0;
    endcase
  end

  assign ctl_we    = (st == S_PRM) || (st == S_ON) || (st == S_STRT) ||
                     (st == S_FRC) || (st == S_OFF);
  assign locked    = (st == S_DONE);
  assign lock_fail = (st == S_FAIL);

  a_r2_on_then_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_word == ((INIT_WORD & ~32'h3) | 32'h2)) |=>
      (ctl_we && ctl_word == (INIT_WORD | 32'h3)));

  a_r6_off_after_force: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_word[0] && !ctl_word[1]) |-> ($past(ctl_we) && $past(ctl_word[1])));

  a_r7_locked_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ctl_we));

  a_r7_locked_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && !ctl_we));

  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_fail |=> (lock_fail && !ctl_we));

  a_r8_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && lock_fail));
endmodule

// File: tb/dll_lock_ctrl_bench.sv
module dll_lock_ctrl_bench;
  localparam int CLK_NS = 10;
  localparam int TMO = 40;
  localparam logic [31:0] INIT = 32'h0010_1000;
  localparam int NV = 5;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 4'd0, 8'hA5}, {1'b1, 4'd5, 8'h3C}, {1'b0, 4'd2, 8'hFF},
    {1'b1, 4'd0, 8'h00}, {1'b0, 4'd9, 8'h81}};

  logic clk = 0, rst_n = 0, go = 0, dll_off = 0;
  logic [7:0] poll_gap = 0;
  logic [31:0] stat_word = 0;
  logic [31:0] ctl_word;
  logic ctl_we, locked, lock_fail;

  int total = 0, bad = 0, cyc = 0, wcnt = 0;
  int lk_cyc = -1, fl_cyc = -1;
  logic [31:0] wlog [8];
  int wst [8];
  logic lk_prev = 0, fl_prev = 0;

  dll_lock_ctrl #(.INIT_WORD(INIT), .GAP_W(8), .TMO_LIM(TMO)) u_dll_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .dll_off(dll_off), .poll_gap(poll_gap),
    .stat_word(stat_word), .ctl_word(ctl_word), .ctl_we(ctl_we),
    .locked(locked), .lock_fail(lock_fail));

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && ctl_we && wcnt < 8) begin
      wlog[wcnt] <= ctl_word;
      wst[wcnt]  <= cyc;
      wcnt       <= wcnt + 1;
    end
    if (locked && !lk_prev) lk_cyc <= cyc;
    if (lock_fail && !fl_prev) fl_cyc <= cyc;
    lk_prev <= locked;
    fl_prev <= lock_fail;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; go = 0;
    repeat (3) @(negedge clk);
    wcnt = 0; lk_cyc = -1; fl_cyc = -1;
    rst_n = 1;
  endtask

  task automatic pulse_go(logic off);
    @(negedge clk);
    dll_off = off; go = 1;
    @(negedge clk);
    go = 0; dll_off = 0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    rst_n = 0;
    cycles(2);
    chk("R1 we", ctl_we, 0);
    chk("R1 locked", locked, 0);
    chk("R1 fail", lock_fail, 0);
    do_reset();
    cycles(2);
    chk("R1 after reset", {ctl_we, locked, lock_fail}, 0);

    // table: lock reported from start
    for (int i = 0; i < NV; i++) begin
      logic off; logic [3:0] g; logic [7:0] v; logic [31:0] fw; int nexp;
      {off, g, v} = VEC[i];
      do_reset();
      poll_gap = 8'(g);
      stat_word = 32'hAAAA_C028 | (32'(v) << 6) | 32'h7;
      stat_word[13:6] = v;
      pulse_go(off);
      cycles(30);
      nexp = off ? 5 : 4;
      fw = (INIT & 32'h00FF_FFFF) | {v, 24'h0} | 32'h3;
      chk("R6 write count", wcnt, nexp);
      chk("R2 param write", wlog[0], INIT);
      chk("R2 on write", wlog[1], INIT | 32'h2);
      chk("R2 start write", wlog[2], INIT | 32'h3);
      chk("R2 consecutive", wst[2] - wst[0], 2);
      chk("R5 force word", wlog[3], fw);
      chk("R4 force delay", wst[3] - wst[2], 32'(g) + 2);
      if (off) begin
        chk("R6 off word", wlog[4], fw & ~32'h2);
        chk("R6 off timing", wst[4] - wst[3], 1);
      end
      chk("R7 locked rise", lk_cyc - wst[nexp-1], 1);
      chk("R7 locked level", locked, 1);
      chk("R8 no fail", lock_fail, 0);
      // R9 go after done ignored
      pulse_go(1'b1);
      cycles(10);
      chk("R9 go after done", wcnt, nexp);
      chk("R7 locked held", locked, 1);
    end

    // R3 partial lock patterns, R9 go while busy
    do_reset();
    poll_gap = 8'd1;
    stat_word = 32'h0000_0006;
    pulse_go(1'b0);
    cycles(5);
    stat_word = 32'h0000_0003;
    pulse_go(1'b1);
    cycles(8);
    chk("R3 no write on partial", wcnt, 3);
    chk("R3 not locked", locked, 0);
    stat_word = 32'h0000_1547;
    cycles(10);
    chk("R3 lock on 111", wcnt, 4);
    chk("R9 go while busy", wlog[3], (INIT & 32'h00FF_FFFF) | 32'h5500_0003);
    chk("R7 locked", locked, 1);

    // R8 timeout
    do_reset();
    poll_gap = 8'd3;
    stat_word = 32'h0000_0005;
    pulse_go(1'b0);
    cycles(TMO + 10);
    chk("R8 fail timing", fl_cyc - wst[2], TMO + 1);
    chk("R8 no further write", wcnt, 3);
    chk("R8 fail level", lock_fail, 1);
    chk("R8 not locked", locked, 0);
    stat_word = 32'h0000_0007;
    pulse_go(1'b0);
    cycles(10);
    chk("R8 fail held", lock_fail, 1);
    chk("R9 go after fail", wcnt, 3);

    do_reset();
    cycles(2);
    chk("R1 reset clears", {ctl_we, locked, lock_fail}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule